// File: doc/BRIEF.md
# Receive Frame Priority and Size Classifier

This block watches a received Ethernet frame as it streams past one byte per accepted cycle. It counts the bytes and looks at the destination address, the length/type field and the tag control field. When the last byte arrives, it produces a verdict. The verdict gives the frame's priority and whether that priority falls in the high or the low class. It names a size/error category using a configurable maximum length and the error flags that come with the last byte. It says whether a low-class frame should be thrown away because receive buffers are short. It also says whether the frame is a broadcast that must be steered to one configured channel.

The byte count runs from the destination address through the frame check sequence. Bytes are accepted only while `in_valid` is high, so idle gaps inside a frame are allowed. The first byte of a frame carries `in_sof` and the last carries `in_eof`. The CRC, alignment and code error flags are sampled together with the last byte. The verdict registers are loaded when the last byte is accepted. `out_valid` pulses for exactly one cycle to mark them.

Top module: `rx_frame_classifier`

## Requirements
- R1: `out_valid` is high for exactly the one cycle after a byte with `in_valid` and `in_eof` is accepted, and low at all other times. Cycles with `in_valid` low add nothing to the frame.
- R2: The frame length is the number of accepted bytes from the `in_sof` byte through the `in_eof` byte, inclusive.
- R3: A frame is tagged when byte 12 (counting from 0) is 81h and byte 13 is 00h. `out_prio` is then bits 7:5 of byte 14, the top three bits of the tag control field. Otherwise `out_prio` is 0. A frame too short to contain byte 14 also gives 0.
- R4: `out_high` is 1 when `out_prio` is 4 to 7 and 0 when it is 0 to 3. Untagged frames are therefore low class.
- R5: `out_category` is 0 (good) for a length from 64 up to `max_len` inclusive with none of the three error flags set.
- R6: For a length below 64, `out_category` is 1 (undersized) with no error flag and 2 (fragment) with any error flag.
- R7: For a length above `max_len`, `out_category` is 3 (oversized) with no error flag and 4 (jabber) with any error flag.
- R8: For a length from 64 to `max_len` with any error flag, `out_category` is 5 (errored).
- R9: `out_drop` is 1 exactly when `qos_en` is 1, the frame is low class, `low_thresh` is nonzero and `free_bufs` is less than or equal to `low_thresh`. These inputs are sampled with the last byte.
- R10: A `low_thresh` of 0 never yields `out_drop`, whatever the buffer count.
- R11: When `bcast_en` is 1 and bytes 0 to 5 are all FFh, `out_bcast` is 1 and `out_chan` equals `bcast_chan`. In every other case `out_bcast` and `out_chan` are 0. A frame shorter than 6 bytes is never broadcast.
- R12: After reset, `out_valid` is 0 and every verdict output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_sof | input | 1 | Presented byte is the first of a frame |
| in_eof | input | 1 | Presented byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| crc_err | input | 1 | CRC error, sampled with the last byte |
| align_err | input | 1 | Alignment error, sampled with the last byte |
| code_err | input | 1 | Code error, sampled with the last byte |
| max_len | input | LEN_W | Largest good frame length in bytes (typically 1518) |
| qos_en | input | 1 | Enables low-priority dropping |
| low_thresh | input | BUF_W | Free-buffer threshold for low-class frames |
| free_bufs | input | BUF_W | Current free-buffer count |
| bcast_en | input | 1 | Enables broadcast steering |
| bcast_chan | input | CH_W | Channel that receives broadcast frames |
| out_valid | output | 1 | One-cycle verdict strobe |
| out_category | output | 3 | Size/error category code |
| out_prio | output | 3 | Priority from the tag control field |
| out_high | output | 1 | High priority class |
| out_drop | output | 1 | Drop this low-class frame |
| out_bcast | output | 1 | Broadcast frame steered to `out_chan` |
| out_chan | output | CH_W | Broadcast channel |

## Verification
The bench targets several boundary cases, and each one catches a specific mistake:

- **Lengths 63, 64, `max_len` and `max_len`+1, with and without errors.** An off-by-one in the length counter or in the limit comparison moves a frame into the neighbouring category.
- **Idle gaps inside frames.** A counter that advances on every cycle instead of on accepted bytes misreads both the length and the tag position.
- **Tags whose priority sits at 3 and at 4, and a tagged type on a frame that ends before byte 14.** These expose a wrong bit slice or a stale priority from an earlier frame.
- **Buffer counts equal to and one above the threshold, and a threshold of zero.** These catch a strict comparison and the missing disable case.
- **Broadcast addresses on 5-byte frames and with steering disabled.** These catch steering that ignores the enable or accepts a partial address.

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier #(
  parameter int LEN_W   = 16,
  parameter int BUF_W   = 8,
  parameter int CH_W    = 3,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic             crc_err,
  input  logic             align_err,
  input  logic             code_err,
  input  logic [LEN_W-1:0] max_len,
  input  logic             qos_en,
  input  logic [BUF_W-1:0] low_thresh,
  input  logic [BUF_W-1:0] free_bufs,
  input  logic             bcast_en,
  input  logic [CH_W-1:0]  bcast_chan,
  output logic             out_valid,
  output logic [2:0]       out_category,
  output logic [2:0]       out_prio,
  output logic             out_high,
  output logic             out_drop,
  output logic             out_bcast,
  output logic [CH_W-1:0]  out_chan
);

  localparam logic [LEN_W-1:0] LEN_SAT = '1;
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);
  localparam logic [2:0] CAT_GOOD  = 3'd0;
  localparam logic [2:0] CAT_UNDER = 3'd1;
  localparam logic [2:0] CAT_FRAG  = 3'd2;
  localparam logic [2:0] CAT_OVER  = 3'd3;
  localparam logic [2:0] CAT_JAB   = 3'd4;
  localparam logic [2:0] CAT_ERR   = 3'd5;

  logic [LEN_W-1:0] cnt;
  logic             type_hi, vlan, da_ff;
  logic [2:0]       prio;

  logic [LEN_W-1:0] cnt_b, len_n;
  logic             type_hi_b, vlan_b, da_b;
  logic [2:0]       prio_b;
  logic             type_hi_n, vlan_n, da_n;
  logic [2:0]       prio_n, cat_n;
  logic             any_err, bc_n, drop_n, last;

  assign cnt_b     = in_sof ? '0   : cnt;
  assign type_hi_b = in_sof ? 1'b0 : type_hi;
  assign vlan_b    = in_sof ? 1'b0 : vlan;
  assign prio_b    = in_sof ? 3'd0 : prio;
  assign da_b      = in_sof ? 1'b1 : da_ff;

  assign len_n     = (cnt_b == LEN_SAT) ? LEN_SAT : cnt_b + 1'b1;
  assign type_hi_n = (cnt_b == LEN_W'(12)) ? (in_data == 8'h81) : type_hi_b;
  assign vlan_n    = (cnt_b == LEN_W'(13)) ? (type_hi_b && in_data == 8'h00) : vlan_b;
  assign prio_n    = (cnt_b == LEN_W'(14) && vlan_b) ? in_data[7:5] : prio_b;
  assign da_n      = (cnt_b < LEN_W'(6)) ? (da_b && in_data == 8'hFF) : da_b;

  assign any_err = crc_err | align_err | code_err;
  assign last    = in_valid & in_eof;

  always_comb begin
    if (len_n < LEN_MIN)      cat_n = any_err ? CAT_FRAG : CAT_UNDER;
    else if (len_n > max_len) cat_n = any_err ? CAT_JAB  : CAT_OVER;
    else                      cat_n = any_err ? CAT_ERR  : CAT_GOOD;
  end

  assign bc_n   = bcast_en && da_n && (len_n >= LEN_W'(6));
  assign drop_n = qos_en && !prio_n[2] && (low_thresh != '0) && (free_bufs <= low_thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      type_hi      <= 1'b0;
      vlan         <= 1'b0;
      prio         <= 3'd0;
      da_ff        <= 1'b0;
      out_valid    <= 1'b0;
      out_category <= 3'd0;
      out_prio     <= 3'd0;
      out_high     <= 1'b0;
      out_drop     <= 1'b0;
      out_bcast    <= 1'b0;
      out_chan     <= '0;
    end else begin
      out_valid <= last;
      if (in_valid) begin
        cnt     <= len_n;
        type_hi <= type_hi_n;
        vlan    <= vlan_n;
        prio    <= prio_n;
        da_ff   <= da_n;
      end
      if (last) begin
        out_category <= cat_n;
        out_prio     <= prio_n;
        out_high     <= prio_n[2];
        out_drop     <= drop_n;
        out_bcast    <= bc_n;
        out_chan     <= bc_n ? bcast_chan : '0;
      end
    end
  end

endmodule

// File: rtl/rx_frame_classifier_chk.sv
module rx_frame_classifier_chk #(
  parameter int BUF_W = 8,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_eof,
  input logic             qos_en,
  input logic [BUF_W-1:0] low_thresh,
  input logic [BUF_W-1:0] free_bufs,
  input logic [CH_W-1:0]  bcast_chan,
  input logic             out_valid,
  input logic [2:0]       out_category,
  input logic             out_high,
  input logic             out_drop,
  input logic             out_bcast,
  input logic [CH_W-1:0]  out_chan
);

  // R1
  pulse_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_eof));

  // R1
  eof_gives_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof) |=> out_valid);

  // R9
  drop_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_drop) |-> !out_high);

  // R9
  drop_needs_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_drop) |-> ($past(qos_en) && ($past(free_bufs) <= $past(low_thresh))));

  // R10
  zero_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(low_thresh) == '0) |-> !out_drop);

  // R11
  bcast_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bcast) |-> (out_chan == $past(bcast_chan)));

  // R8
  category_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_category <= 3'd5));

endmodule

bind rx_frame_classifier rx_frame_classifier_chk #(.BUF_W(BUF_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
  .qos_en(qos_en), .low_thresh(low_thresh), .free_bufs(free_bufs),
  .bcast_chan(bcast_chan), .out_valid(out_valid), .out_category(out_category),
  .out_high(out_high), .out_drop(out_drop), .out_bcast(out_bcast), .out_chan(out_chan)
);

// File: tb/rx_frame_classifier_bench.sv
module rx_frame_classifier_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        crc_err, align_err, code_err;
  logic [15:0] max_len;
  logic        qos_en;
  logic [7:0]  low_thresh, free_bufs;
  logic        bcast_en;
  logic [2:0]  bcast_chan;
  logic        out_valid;
  logic [2:0]  out_category, out_prio;
  logic        out_high, out_drop, out_bcast;
  logic [2:0]  out_chan;

  int checks = 0;
  int fails  = 0;
  logic [7:0] fr [0:2047];

  always #(PERIOD/2) clk = ~clk;

  rx_frame_classifier u_rx_frame_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .crc_err(crc_err), .align_err(align_err), .code_err(code_err),
    .max_len(max_len), .qos_en(qos_en), .low_thresh(low_thresh), .free_bufs(free_bufs),
    .bcast_en(bcast_en), .bcast_chan(bcast_chan), .out_valid(out_valid),
    .out_category(out_category), .out_prio(out_prio), .out_high(out_high),
    .out_drop(out_drop), .out_bcast(out_bcast), .out_chan(out_chan)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_cat(input int len, input bit err, input int mx);
    if (len < 64) return err ? 2 : 1;
    if (len > mx) return err ? 4 : 3;
    return err ? 5 : 0;
  endfunction

  function automatic int exp_prio(input int len);
    if (len >= 15 && fr[12] == 8'h81 && fr[13] == 8'h00) return int'(fr[14][7:5]);
    return 0;
  endfunction

  function automatic bit exp_bc(input int len);
    if (!bcast_en || len < 6) return 1'b0;
    for (int i = 0; i < 6; i++) if (fr[i] != 8'hFF) return 1'b0;
    return 1'b1;
  endfunction

  task automatic send(input int len, input bit ce, input bit ae, input bit de, input bit gaps);
    int p, ep;
    bit eb, err;
    err = ce | ae | de;
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        in_data = 8'($urandom);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_eof = (i == len - 1);
      in_data = fr[i];
      crc_err = ce; align_err = ae; code_err = de;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    crc_err = 1'b0; align_err = 1'b0; code_err = 1'b0;
    p  = exp_prio(len);
    eb = exp_bc(len);
    ep = (qos_en && p < 4 && low_thresh != 0 && free_bufs <= low_thresh) ? 1 : 0;
    chk("R1 valid pulse", int'(out_valid), 1);
    chk("R2/R5/R6/R7/R8 category", int'(out_category), exp_cat(len, err, int'(max_len)));
    chk("R3 priority", int'(out_prio), p);
    chk("R4 class", int'(out_high), (p >= 4) ? 1 : 0);
    chk("R9/R10 drop", int'(out_drop), ep);
    chk("R11 broadcast", int'(out_bcast), int'(eb));
    chk("R11 channel", int'(out_chan), eb ? int'(bcast_chan) : 0);
    @(negedge clk);
    chk("R1 single cycle", int'(out_valid), 0);
  endtask

  task automatic fill(input int len, input bit bc, input bit tag, input int pr);
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    if (!bc && len >= 6) fr[0] = 8'h00;
    if (bc) for (int i = 0; i < 6; i++) fr[i] = 8'hFF;
    if (tag) begin
      fr[12] = 8'h81;
      fr[13] = 8'h00;
      fr[14] = {3'(pr), 5'($urandom)};
    end else begin
      fr[12] = 8'h08;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    crc_err = 1'b0; align_err = 1'b0; code_err = 1'b0;
    max_len = 16'd1518; qos_en = 1'b0; low_thresh = 8'd0; free_bufs = 8'd10;
    bcast_en = 1'b1; bcast_chan = 3'd5;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 valid", int'(out_valid), 0);
    chk("R12 category", int'(out_category), 0);
    chk("R12 drop", int'(out_drop), 0);
    chk("R12 bcast", int'(out_bcast), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 boundaries around 64
    fill(63, 0, 0, 0); send(63, 0, 0, 0, 0);
    fill(63, 0, 0, 0); send(63, 1, 0, 0, 0);
    fill(64, 0, 0, 0); send(64, 0, 0, 0, 1);
    fill(64, 0, 0, 0); send(64, 0, 0, 1, 0);
    // R7 boundaries around max_len
    max_len = 16'd100;
    fill(100, 0, 0, 0); send(100, 0, 0, 0, 1);
    fill(101, 0, 0, 0); send(101, 0, 0, 0, 0);
    fill(101, 0, 0, 0); send(101, 0, 1, 0, 0);
    max_len = 16'd1518;
    fill(1518, 0, 1, 6); send(1518, 0, 0, 0, 0);
    fill(1519, 0, 0, 0); send(1519, 0, 0, 0, 0);
    // R3 R4 priority 3 vs 4, short tagged frame
    fill(70, 0, 1, 3); send(70, 0, 0, 0, 0);
    fill(70, 0, 1, 4); send(70, 0, 0, 0, 1);
    fill(14, 0, 1, 7); send(14, 0, 0, 0, 0);
    fill(15, 0, 1, 7); send(15, 0, 0, 0, 0);
    // R9 R10 threshold boundaries
    qos_en = 1'b1; low_thresh = 8'd4;
    free_bufs = 8'd4; fill(80, 0, 0, 0); send(80, 0, 0, 0, 0);
    free_bufs = 8'd5; fill(80, 0, 0, 0); send(80, 0, 0, 0, 0);
    free_bufs = 8'd2; fill(80, 0, 1, 5); send(80, 0, 0, 0, 0);
    low_thresh = 8'd0; free_bufs = 8'd0; fill(80, 0, 0, 0); send(80, 0, 0, 0, 0);
    qos_en = 1'b0; low_thresh = 8'd9; fill(80, 0, 0, 0); send(80, 0, 0, 0, 0);
    // R11 broadcast cases
    fill(5, 1, 0, 0);  send(5, 0, 0, 0, 0);
    fill(6, 1, 0, 0);  send(6, 0, 0, 0, 0);
    bcast_en = 1'b0; fill(90, 1, 0, 0); send(90, 0, 0, 0, 0);
    bcast_en = 1'b1; bcast_chan = 3'd2; fill(90, 1, 0, 0); send(90, 0, 0, 0, 1);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int len;
      bit ce, ae, de;
      case ($urandom % 4)
        0: len = 1 + $urandom % 80;
        1: len = 60 + $urandom % 10;
        2: len = int'(max_len) - 2 + $urandom % 5;
        default: len = 64 + $urandom % 400;
      endcase
      ce = ($urandom % 5 == 0); ae = ($urandom % 9 == 0); de = ($urandom % 9 == 0);
      qos_en = 1'($urandom); low_thresh = 8'($urandom % 8); free_bufs = 8'($urandom % 10);
      bcast_en = 1'($urandom); bcast_chan = 3'($urandom);
      if ($urandom % 3 == 0) max_len = 16'(100 + $urandom % 200); else max_len = 16'd1518;
      fill(len, ($urandom % 3 == 0), ($urandom % 2 == 0), int'($urandom % 8));
      send(len, ce, ae, de, 1'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule